// File: doc/BRIEF.md
# SPI Register Transaction Framer

This block is a SPI master that carries out one register access to an attached peripheral for each request. A request gives the direction, a byte count from 1 to 64 and a 24-bit register address. The block lowers chip select and sends a four-byte command header. It then polls the device one byte at a time until the device signals it is ready, moves the data bytes, and raises chip select again. Write data is pulled from the requester one byte per pulse of `wr_take`. Read data is returned as a stream of bytes, each marked by `rd_valid`.

The serial clock idles low, and bytes move most significant bit first. The device may hold the master in the wait phase for several bytes. If the ready bit has not appeared after a set number of poll bytes, the transaction ends with a timeout flag. Each request ends with a single-cycle `done` pulse.

Top module: `spi_reg_framer`

## Requirements
- R1: After reset, `spi_cs_n` is high, `spi_sclk` is low, `req_ready` is high, and `done`, `timeout`, `rd_valid` and `wr_take` are low.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when idle: it goes low after acceptance and rises in the cycle of `done`. A `req_valid` raised while busy starts nothing.
- R3: The first header byte carries the direction in bit 7 (1 = read, 0 = write), a constant 1 in bit 6, and the byte count minus one in bits 5:0.
- R4: Header bytes two to four carry the 24-bit address, most significant byte first.
- R5: `spi_cs_n` falls at acceptance, before the first rising edge of `spi_sclk`. It stays low without a break through the header, the wait polling and the data phase, and rises only when the transaction ends.
- R6: SPI mode 0 is used. `spi_sclk` is low whenever chip select is high. `spi_mosi` changes only while `spi_sclk` is low, and the bits go most significant first. `spi_miso` is sampled on the rising edge. Each high phase of `spi_sclk` lasts `HALF_DIV` system clocks.
- R7: After the header, the master clocks in single poll bytes with `spi_mosi` held low. It keeps polling until a received poll byte has bit 0 (the last bit received) equal to 1. All other bits of a poll byte are ignored, and so are the bytes received during the header. The first data byte follows the ready poll byte directly.
- R8: A write sends exactly the requested number of bytes from `wr_data`, in order. `wr_take` pulses once per byte, in the cycle where the byte is loaded.
- R9: A read pulses `rd_valid` once per received data byte, in order, with the byte on `rd_data`. `spi_mosi` is low during the read data phase.
- R10: `done` is a one-cycle pulse that comes once per accepted request, in the cycle where `spi_cs_n` rises. `timeout` is low on a normal completion.
- R11: If `POLL_LIMIT` poll bytes in a row all have bit 0 equal to 0, chip select is raised with no data phase, and `done` and `timeout` pulse together. No `rd_valid` or `wr_take` occurs for that request.
- R12: Byte counts of 1 and 64 both complete with exactly that many data bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_read | input | 1 | 1 = read, 0 = write |
| req_len | input | 7 | Data byte count, 1 to 64 |
| req_addr | input | 24 | Register address |
| wr_data | input | 8 | Next write data byte |
| wr_take | output | 1 | Pulse: `wr_data` consumed this cycle |
| rd_valid | output | 1 | Pulse: `rd_data` holds a received byte |
| rd_data | output | 8 | Received data byte |
| done | output | 1 | Pulse: transaction finished |
| timeout | output | 1 | Pulse with `done` when wait polling gave up |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Master-out serial data |
| spi_miso | input | 1 | Master-in serial data |

## Verification
The bench builds the block with `HALF_DIV` = 2 and `POLL_LIMIT` = 6. The short serial clock keeps full 64-byte reads and writes to a few thousand cycles. The small poll limit lets a device model stall for exactly the limit minus one bytes, which must still succeed, and for the full limit, which must time out. The device model answers header bytes with bit 0 low and stall bytes with every other bit high, so the bench also shows that only the last bit of a poll byte is examined.

// File: rtl/spi_frm_pkg.sv
package spi_frm_pkg;

    localparam int HDR_BYTES = 4;
    localparam int MAX_BYTES = 64;
    localparam int LEN_W     = $clog2(MAX_BYTES + 1);
    localparam int CNT_W     = $clog2(MAX_BYTES);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_POLL,
        ST_DATA
    } frm_state_e;

    function automatic logic [7:0] hdr_byte(
        input logic             rd,
        input logic [CNT_W-1:0] len_m1,
        input logic [23:0]      addr,
        input logic [1:0]       idx
    );
        logic [7:0] b;
        case (idx)
            2'd0:    b = {rd, 1'b1, len_m1};
            2'd1:    b = addr[23:16];
            2'd2:    b = addr[15:8];
            default: b = addr[7:0];
        endcase
        return b;
    endfunction

endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == CW'(HALF_DIV - 1));
        cnt_d = cnt_q;
        if (!run || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/spi_byte_shift.sv
module spi_byte_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       busy,
    output logic       done,
    output logic       sclk,
    output logic       mosi,
    output logic [7:0] rx_byte
);
    typedef struct packed {
        logic       busy;
        logic       done;
        logic       sclk;
        logic       mosi;
        logic [2:0] bitn;
        logic [7:0] tx;
        logic [7:0] rx;
    } shift_t;

    shift_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (start) begin
            s_d.busy = 1'b1;
            s_d.sclk = 1'b0;
            s_d.bitn = '0;
            s_d.tx   = tx_byte;
            s_d.mosi = tx_byte[7];
        end else if (s_q.busy && tick) begin
            if (!s_q.sclk) begin
                s_d.sclk = 1'b1;
                s_d.rx   = {s_q.rx[6:0], miso};
            end else begin
                s_d.sclk = 1'b0;
                if (s_q.bitn == 3'd7) begin
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                    s_d.mosi = 1'b0;
                end else begin
                    s_d.bitn = s_q.bitn + 3'd1;
                    s_d.tx   = {s_q.tx[6:0], 1'b0};
                    s_d.mosi = s_q.tx[6];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy    = s_q.busy;
    assign done    = s_q.done;
    assign sclk    = s_q.sclk;
    assign mosi    = s_q.mosi;
    assign rx_byte = s_q.rx;

    // R6: data line holds while the serial clock is high
    p_mosi_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.sclk && $past(s_q.sclk)) |-> $stable(s_q.mosi));

    // R6: serial clock moves only on a divider tick
    p_sclk_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !start) |=> $stable(s_q.sclk));

endmodule

// File: rtl/spi_reg_framer.sv
module spi_reg_framer #(
    parameter int HALF_DIV   = 4,
    parameter int POLL_LIMIT = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_read,
    input  logic [6:0]  req_len,
    input  logic [23:0] req_addr,
    input  logic [7:0]  wr_data,
    output logic        wr_take,
    output logic        rd_valid,
    output logic [7:0]  rd_data,
    output logic        done,
    output logic        timeout,
    output logic        spi_sclk,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    import spi_frm_pkg::*;

    localparam int PW = $clog2(POLL_LIMIT + 1);

    typedef struct packed {
        frm_state_e       st;
        logic [1:0]       hdr_idx;
        logic [CNT_W-1:0] dcnt;
        logic [CNT_W-1:0] len_m1;
        logic [PW-1:0]    pcnt;
        logic             is_read;
        logic [23:0]      addr;
        logic             cs_n;
        logic             done;
        logic             timeout;
        logic             rd_valid;
        logic [7:0]       rd_data;
    } frm_t;

    frm_t f_d, f_q;

    logic       tick;
    logic       sh_busy, sh_done, sh_start;
    logic [7:0] sh_tx, sh_rx;

    spi_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (sh_busy),
        .tick  (tick)
    );

    spi_byte_shift u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .start   (sh_start),
        .tx_byte (sh_tx),
        .miso    (spi_miso),
        .busy    (sh_busy),
        .done    (sh_done),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .rx_byte (sh_rx)
    );

    always_comb begin
        logic [CNT_W-1:0] lm1;
        lm1        = CNT_W'(req_len - 7'd1);
        f_d        = f_q;
        f_d.done     = 1'b0;
        f_d.timeout  = 1'b0;
        f_d.rd_valid = 1'b0;
        sh_start   = 1'b0;
        sh_tx      = 8'h00;
        wr_take    = 1'b0;
        case (f_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    f_d.st      = ST_HDR;
                    f_d.is_read = req_read;
                    f_d.len_m1  = lm1;
                    f_d.addr    = req_addr;
                    f_d.hdr_idx = 2'd0;
                    f_d.cs_n    = 1'b0;
                    sh_start    = 1'b1;
                    sh_tx       = hdr_byte(req_read, lm1, req_addr, 2'd0);
                end
            end
            ST_HDR: begin
                if (sh_done) begin
                    sh_start = 1'b1;
                    if (f_q.hdr_idx == 2'(HDR_BYTES - 1)) begin
                        f_d.st   = ST_POLL;
                        f_d.pcnt = '0;
                        sh_tx    = 8'h00;
                    end else begin
                        f_d.hdr_idx = f_q.hdr_idx + 2'd1;
                        sh_tx = hdr_byte(f_q.is_read, f_q.len_m1, f_q.addr,
                                         f_q.hdr_idx + 2'd1);
                    end
                end
            end
            ST_POLL: begin
                if (sh_done) begin
                    if (sh_rx[0]) begin
                        f_d.st   = ST_DATA;
                        f_d.dcnt = '0;
                        sh_start = 1'b1;
                        sh_tx    = f_q.is_read ? 8'h00 : wr_data;
                        wr_take  = !f_q.is_read;
                    end else if (f_q.pcnt == PW'(POLL_LIMIT - 1)) begin
                        f_d.st      = ST_IDLE;
                        f_d.cs_n    = 1'b1;
                        f_d.done    = 1'b1;
                        f_d.timeout = 1'b1;
                    end else begin
                        f_d.pcnt = f_q.pcnt + 1'b1;
                        sh_start = 1'b1;
                        sh_tx    = 8'h00;
                    end
                end
            end
            default: begin
                if (sh_done) begin
                    if (f_q.is_read) begin
                        f_d.rd_valid = 1'b1;
                        f_d.rd_data  = sh_rx;
                    end
                    if (f_q.dcnt == f_q.len_m1) begin
                        f_d.st   = ST_IDLE;
                        f_d.cs_n = 1'b1;
                        f_d.done = 1'b1;
                    end else begin
                        f_d.dcnt = f_q.dcnt + 1'b1;
                        sh_start = 1'b1;
                        sh_tx    = f_q.is_read ? 8'h00 : wr_data;
                        wr_take  = !f_q.is_read;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q      <= '0;
            f_q.st   <= ST_IDLE;
            f_q.cs_n <= 1'b1;
        end else begin
            f_q <= f_d;
        end
    end

    assign req_ready = (f_q.st == ST_IDLE);
    assign rd_valid  = f_q.rd_valid;
    assign rd_data   = f_q.rd_data;
    assign done      = f_q.done;
    assign timeout   = f_q.timeout;
    assign spi_cs_n  = f_q.cs_n;

    // R5: acceptance lowers chip select and drops ready
    p_cs_on_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!spi_cs_n && !req_ready));

    // R10: done coincides with chip select released
    p_done_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> spi_cs_n);

    // R2: ready returns only together with done
    p_ready_with_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_ready) |-> done);

    // R11: timeout is part of done and carries no data
    p_timeout_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (done && !rd_valid));

    // R6: clock idles low outside a transaction
    p_idle_sclk_r6: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

endmodule

// File: tb/spi_reg_framer_tb.sv
module spi_reg_framer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_DIV   = 2;
    localparam int POLL_LIMIT = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_read = 1'b0;
    logic [6:0]  req_len = 7'd1;
    logic [23:0] req_addr = '0;
    logic [7:0]  wr_data;
    logic        wr_take, rd_valid, done, timeout;
    logic [7:0]  rd_data;
    logic        spi_sclk, spi_cs_n, spi_mosi;
    logic        spi_miso;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_reg_framer #(.HALF_DIV(HALF_DIV), .POLL_LIMIT(POLL_LIMIT)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_read(req_read), .req_len(req_len), .req_addr(req_addr),
        .wr_data(wr_data), .wr_take(wr_take), .rd_valid(rd_valid),
        .rd_data(rd_data), .done(done), .timeout(timeout),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    int checks = 0;
    int errors = 0;
    int mon_checks = 0;
    int mon_errors = 0;

    // device model configuration (written by the stimulus only)
    int         dev_waits = 0;
    logic [7:0] dev_rd [64];

    // device model state
    int         dev_bits = 0;
    logic [7:0] dev_sh = '0;
    logic [7:0] cap [1024];
    int         cap_n = 0;
    logic       miso_r = 1'b0;
    assign spi_miso = miso_r;

    function automatic logic [7:0] dev_byte(input int k);
        int p;
        if (k < 4) return 8'h5A;
        p = k - 4;
        if (p < dev_waits) return 8'hFE;
        if (p == dev_waits) return 8'h03;
        if (p - dev_waits - 1 < 64) return dev_rd[p - dev_waits - 1];
        return 8'h00;
    endfunction

    always @(posedge spi_sclk or posedge spi_cs_n) begin
        if (spi_cs_n) begin
            dev_bits = 0;
        end else begin
            dev_sh = {dev_sh[6:0], spi_mosi};
            dev_bits = dev_bits + 1;
            if (dev_bits % 8 == 0) begin
                cap[cap_n % 1024] = dev_sh;
                cap_n = cap_n + 1;
            end
        end
        miso_r = dev_byte(dev_bits / 8)[7 - (dev_bits % 8)];
    end

    // write data source and monitor
    logic [7:0] wr_arr [256];
    logic [7:0] wr_idx = '0;
    logic       take_pend = 1'b0;
    int         take_cnt = 0;
    assign wr_data = wr_arr[wr_idx];

    logic [7:0] rd_arr [256];
    int         rd_n = 0;
    int         done_cnt = 0;
    logic       last_to = 1'b0;
    logic       busy_m = 1'b0;
    int         hi_run = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (take_pend) wr_idx = wr_idx + 8'd1;
            take_pend = wr_take;
            if (wr_take) take_cnt = take_cnt + 1;
            if (rd_valid) begin
                rd_arr[rd_n % 256] = rd_data;
                rd_n = rd_n + 1;
            end
            if (done) begin
                done_cnt = done_cnt + 1;
                last_to = timeout;
                busy_m = 1'b0;
            end
            mon_checks = mon_checks + 1;
            if (req_ready !== !busy_m) begin
                mon_errors = mon_errors + 1;
                $display("FAIL R2 req_ready=%0b expected %0b", req_ready, !busy_m);
            end
            mon_checks = mon_checks + 1;
            if (spi_cs_n !== !busy_m) begin
                mon_errors = mon_errors + 1;
                $display("FAIL R5 spi_cs_n=%0b expected %0b", spi_cs_n, !busy_m);
            end
            mon_checks = mon_checks + 1;
            if (spi_cs_n && spi_sclk) begin
                mon_errors = mon_errors + 1;
                $display("FAIL R6 sclk=%0b expected 0 with cs high", spi_sclk);
            end
            if (spi_sclk) begin
                hi_run = hi_run + 1;
            end else if (hi_run != 0) begin
                mon_checks = mon_checks + 1;
                if (hi_run != HALF_DIV) begin
                    mon_errors = mon_errors + 1;
                    $display("FAIL R6 sclk high %0d clocks expected %0d", hi_run, HALF_DIV);
                end
                hi_run = 0;
            end
            if (req_valid && req_ready) busy_m = 1'b1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    int cap_base, rd_base, take_base, done_base;

    task automatic issue(input logic rd, input int len, input logic [23:0] addr,
                         input int waits);
        dev_waits = waits;
        for (int i = 0; i < 64; i++) begin
            dev_rd[i] = 8'(addr[7:0] ^ (i * 37 + 11));
            wr_arr[8'(int'(wr_idx) + i)] = 8'(addr[15:8] + i * 13 + 5);
        end
        cap_base = cap_n; rd_base = rd_n; take_base = take_cnt; done_base = done_cnt;
        @(negedge clk);
        req_read = rd; req_len = 7'(len); req_addr = addr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_txn(input logic rd, input int len, input logic [23:0] addr,
                              input int waits, input logic exp_to, input string tag);
        int n_poll, n_data, wr_start;
        logic [7:0] eb;
        for (int i = 0; i < 20000 && done_cnt == done_base; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        check({tag, " R10 done count"}, done_cnt - done_base, 1);
        check({tag, " R11 timeout flag"}, int'(last_to), int'(exp_to));
        n_poll = exp_to ? POLL_LIMIT : waits + 1;
        n_data = exp_to ? 0 : len;
        check({tag, " R5 frame byte count"}, cap_n - cap_base, 4 + n_poll + n_data);
        check({tag, " R3 header byte 0"}, int'(cap[cap_base % 1024]),
              int'({rd, 1'b1, 6'(len - 1)}));
        check({tag, " R4 address high"}, int'(cap[(cap_base + 1) % 1024]), int'(addr[23:16]));
        check({tag, " R4 address mid"}, int'(cap[(cap_base + 2) % 1024]), int'(addr[15:8]));
        check({tag, " R4 address low"}, int'(cap[(cap_base + 3) % 1024]), int'(addr[7:0]));
        for (int i = 0; i < n_poll; i++)
            check({tag, " R7 poll byte mosi low"}, int'(cap[(cap_base + 4 + i) % 1024]), 0);
        wr_start = int'(wr_idx) - (take_cnt - take_base);
        for (int i = 0; i < n_data; i++) begin
            eb = rd ? 8'h00 : wr_arr[8'(wr_start + i)];
            check({tag, rd ? " R9 read mosi low" : " R8 write byte"},
                  int'(cap[(cap_base + 4 + n_poll + i) % 1024]), int'(eb));
        end
        check({tag, " R8 wr_take pulses"}, take_cnt - take_base, rd ? 0 : n_data);
        check({tag, " R9 rd_valid pulses"}, rd_n - rd_base, rd ? n_data : 0);
        if (rd)
            for (int i = 0; i < n_data; i++)
                check({tag, " R9 read byte"}, int'(rd_arr[(rd_base + i) % 256]),
                      int'(dev_rd[i]));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 cs_n after reset", int'(spi_cs_n), 1);
        check("R1 sclk after reset", int'(spi_sclk), 0);
        check("R1 ready after reset", int'(req_ready), 1);
        check("R1 pulses after reset", int'({done, timeout, rd_valid, wr_take}), 0);

        issue(1'b0, 4, 24'h000018, 0);
        finish_txn(1'b0, 4, 24'h000018, 0, 1'b0, "write4");

        issue(1'b1, 4, 24'hABCDEF, 3);
        finish_txn(1'b1, 4, 24'hABCDEF, 3, 1'b0, "read4");

        issue(1'b1, 1, 24'h000F00, 0);
        finish_txn(1'b1, 1, 24'h000F00, 0, 1'b0, "R12 read1");

        issue(1'b0, 64, 24'h123456, 2);
        finish_txn(1'b0, 64, 24'h123456, 2, 1'b0, "R12 write64");

        issue(1'b1, 64, 24'h00F004, POLL_LIMIT - 1);
        finish_txn(1'b1, 64, 24'h00F004, POLL_LIMIT - 1, 1'b0, "R7 read64 max wait");

        issue(1'b1, 8, 24'h0A0B0C, POLL_LIMIT);
        finish_txn(1'b1, 8, 24'h0A0B0C, POLL_LIMIT, 1'b1, "R11 timeout");

        // R2: a request raised while busy must start nothing
        issue(1'b0, 2, 24'h445566, 1);
        repeat (30) @(negedge clk);
        req_read = 1'b1; req_len = 7'd9; req_addr = 24'h999999; req_valid = 1'b1;
        repeat (10) @(negedge clk);
        req_valid = 1'b0;
        finish_txn(1'b0, 2, 24'h445566, 1, 1'b0, "R2 busy request");
        repeat (40) @(negedge clk);
        check("R2 no second transaction", done_cnt - done_base, 1);
        check("R2 cs_n stays high", int'(spi_cs_n), 1);

        issue(1'b0, 1, 24'hFEDCBA, 0);
        finish_txn(1'b0, 1, 24'hFEDCBA, 0, 1'b0, "R12 write1 after timeout");

        $display("CHECKS %0d ERRORS %0d", checks + mon_checks, errors + mon_errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks + mon_checks + 1, errors + mon_errors + 1);
        $finish;
    end

endmodule